// File: doc/BRIEF.md
# Abstract Command Controller

This block tracks whether an abstract debug command is in flight and what went wrong with the most recent attempt to start one. A host writes a 32-bit command word. If no error is pending, the controller is idle and the command is supported, the block raises a one-cycle launch pulse toward the hart-side sequencer and goes busy. It also records the command word for later re-use. Busy drops only when both of these hold: the hart has reported completion, and a countdown of run-test-idle ticks, loaded from a configuration input at launch, has reached zero.

The block also owns a small set of data words and program-buffer words. It guards them while a command runs. A read during busy returns all ones and a write during busy is dropped. A data-word access during busy also records a sticky busy error. Two auto-execute masks, one per word group, make an access to a selected word re-run the stored command once the controller is idle. Errors are a 3-bit sticky code that the host clears by writing ones to the bits it wants cleared.

Top module: `abs_cmd_ctrl`

## Requirements
- R1: After reset, busy is 0, the error code is 0, launch is 0, the stored command is 0 and every data and program-buffer word reads 0.
- R2: A command is launched only when the error code is 0, busy is 0, bits 31:24 of the command are zero and hart_halted is 1. On launch, launch is high for exactly the cycle after the request and busy is 1 from that cycle on. cmd_out holds the last command word written.
- R3: A command write while the error code is nonzero launches nothing and leaves the error code unchanged.
- R4: A command start while busy sets the error code to 1 (busy).
- R5: A command start with a nonzero bits 31:24 sets the error code to 2 (not supported). A command start while hart_halted is 0 sets it to 4 (halt/resume state). The top-byte check comes first.
- R6: Launch loads a countdown from idle_cfg and clears the completion record. Each rti_tick decrements the countdown while it is nonzero. Completion is recorded from a hart_done pulse while busy. Busy clears only on an rti_tick where, after the decrement, the count is 0 and completion is recorded; a hart_done in that same cycle counts.
- R7: While busy, a read of any in-range data or program-buffer word returns all ones. When idle, it returns the stored word. An index beyond the group size reads 0.
- R8: While busy, writes to data and program-buffer words are discarded. A data-word access sets the error code to 1 if it was 0. A program-buffer access leaves the error code unchanged.
- R9: When idle, an access to data word i re-runs the stored command, under the rules of R2 to R5, if bit i of the data auto-execute mask is set. Program-buffer word i does the same with its own mask.
- R10: A status write clears exactly the error bits set in stat_clr. While no status write occurs, a nonzero error code holds.
- R11: hart_exc sets the error code to 3 (exception) when it would otherwise be 0 at the next edge.
- R12: When several host operations arrive in one cycle, only one is taken, in the order command write, status write, mask write, word access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_cfg | input | CNT_W | Idle-tick count loaded at launch |
| hart_halted | input | 1 | Selected hart is halted |
| hart_done | input | 1 | Hart reports command completion |
| hart_exc | input | 1 | Hart reports an exception during the command |
| rti_tick | input | 1 | One run-test-idle tick |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | WORD_W | Command word |
| stat_wr | input | 1 | Status write strobe |
| stat_clr | input | 3 | Error bits to clear |
| auto_wr | input | 1 | Auto-execute mask write strobe |
| auto_data_mask | input | DATA_WORDS | Data-word auto-execute mask |
| auto_prog_mask | input | PROG_WORDS | Program-buffer auto-execute mask |
| acc_req | input | 1 | Word access strobe |
| acc_prog | input | 1 | 1 selects program buffer, 0 data words |
| acc_we | input | 1 | Access is a write |
| acc_idx | input | IDX_W | Word index in the selected group |
| acc_wdata | input | WORD_W | Write data |
| acc_rdata | output | WORD_W | Read data for the current access |
| busy | output | 1 | Command in flight |
| cmd_err | output | 3 | Sticky error code |
| launch | output | 1 | One-cycle command dispatch pulse |
| cmd_out | output | WORD_W | Stored command word |

## Verification
Most faults in the busy, countdown or completion state appear as a wrong busy level on the tick that should release it. Because guarded reads return all ones from busy state, the same fault also shows on acc_rdata within one cycle. A lost or stuck error code shows on cmd_err one edge after the request that should have set or kept it, and it also blocks or allows a launch pulse that the reference model predicts. A dropped or wrongly accepted guarded write stays latent until the next idle read of that word. The directed sequence therefore reads each such word back right after release.

// File: rtl/abs_cmd_ctrl.sv
module abs_cmd_ctrl #(
  parameter int WORD_W     = 32,
  parameter int DATA_WORDS = 2,
  parameter int PROG_WORDS = 4,
  parameter int CNT_W      = 8,
  localparam int MAXW  = (DATA_WORDS > PROG_WORDS) ? DATA_WORDS : PROG_WORDS,
  localparam int IDX_W = (MAXW > 1) ? $clog2(MAXW) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W-1:0]      idle_cfg,
  input  logic                  hart_halted,
  input  logic                  hart_done,
  input  logic                  hart_exc,
  input  logic                  rti_tick,
  input  logic                  cmd_wr,
  input  logic [WORD_W-1:0]     cmd_wdata,
  input  logic                  stat_wr,
  input  logic [2:0]            stat_clr,
  input  logic                  auto_wr,
  input  logic [DATA_WORDS-1:0] auto_data_mask,
  input  logic [PROG_WORDS-1:0] auto_prog_mask,
  input  logic                  acc_req,
  input  logic                  acc_prog,
  input  logic                  acc_we,
  input  logic [IDX_W-1:0]      acc_idx,
  input  logic [WORD_W-1:0]     acc_wdata,
  output logic [WORD_W-1:0]     acc_rdata,
  output logic                  busy,
  output logic [2:0]            cmd_err,
  output logic                  launch,
  output logic [WORD_W-1:0]     cmd_out
);

  localparam logic [2:0] E_NONE = 3'd0;
  localparam logic [2:0] E_BUSY = 3'd1;
  localparam logic [2:0] E_NSUP = 3'd2;
  localparam logic [2:0] E_EXC  = 3'd3;
  localparam logic [2:0] E_HALT = 3'd4;

  logic                  busy_q, done_q, launch_q;
  logic [2:0]            err_q, err_n;
  logic [CNT_W-1:0]      cnt_q;
  logic [WORD_W-1:0]     cmd_q;
  logic [DATA_WORDS-1:0] dmask_q;
  logic [PROG_WORDS-1:0] pmask_q;
  logic [WORD_W-1:0]     data_q [DATA_WORDS];
  logic [WORD_W-1:0]     prog_q [PROG_WORDS];

  logic op_cmd, op_stat, op_auto, op_acc;
  assign op_cmd  = cmd_wr;
  assign op_stat = !cmd_wr && stat_wr;
  assign op_auto = !cmd_wr && !stat_wr && auto_wr;
  assign op_acc  = !cmd_wr && !stat_wr && !auto_wr && acc_req;

  logic [DATA_WORDS-1:0] dsel;
  logic [PROG_WORDS-1:0] psel;
  logic data_hit, prog_hit;

  for (genvar i = 0; i < DATA_WORDS; i++) begin : g_dsel
    assign dsel[i] = op_acc && !acc_prog && (int'(acc_idx) == i);
  end
  for (genvar i = 0; i < PROG_WORDS; i++) begin : g_psel
    assign psel[i] = op_acc && acc_prog && (int'(acc_idx) == i);
  end

  assign data_hit = |dsel;
  assign prog_hit = |psel;

  logic auto_fire, run_req, go;
  logic [WORD_W-1:0] run_word;

  assign auto_fire = !busy_q && (|(dsel & dmask_q) || |(psel & pmask_q));
  assign run_req   = op_cmd || auto_fire;
  assign run_word  = op_cmd ? cmd_wdata : cmd_q;

  always_comb begin
    err_n = err_q;
    go    = 1'b0;
    if (run_req && err_q == E_NONE) begin
      if (busy_q)
        err_n = E_BUSY;
      else if (run_word[WORD_W-1 -: 8] != 8'd0)
        err_n = E_NSUP;
      else if (!hart_halted)
        err_n = E_HALT;
      else
        go = 1'b1;
    end
    if (op_stat)
      err_n = err_q & ~stat_clr;
    if (data_hit && busy_q && err_q == E_NONE)
      err_n = E_BUSY;
    if (hart_exc && err_n == E_NONE)
      err_n = E_EXC;
  end

  logic [CNT_W-1:0] cnt_dec;
  logic             done_seen;
  assign cnt_dec   = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
  assign done_seen = done_q || hart_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      err_q    <= E_NONE;
      launch_q <= 1'b0;
      cmd_q    <= '0;
      dmask_q  <= '0;
      pmask_q  <= '0;
    end else begin
      err_q    <= err_n;
      launch_q <= go;
      if (op_cmd)
        cmd_q <= cmd_wdata;
      if (op_auto) begin
        dmask_q <= auto_data_mask;
        pmask_q <= auto_prog_mask;
      end
      if (go) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        cnt_q  <= idle_cfg;
      end else begin
        if (busy_q && hart_done)
          done_q <= 1'b1;
        if (rti_tick) begin
          cnt_q <= cnt_dec;
          if (busy_q && done_seen && cnt_dec == '0)
            busy_q <= 1'b0;
        end
      end
    end
  end

  for (genvar i = 0; i < DATA_WORDS; i++) begin : g_data
    always_ff @(posedge clk) begin
      if (!rst_n)
        data_q[i] <= '0;
      else if (dsel[i] && acc_we && !busy_q)
        data_q[i] <= acc_wdata;
    end
  end

  for (genvar i = 0; i < PROG_WORDS; i++) begin : g_prog
    always_ff @(posedge clk) begin
      if (!rst_n)
        prog_q[i] <= '0;
      else if (psel[i] && acc_we && !busy_q)
        prog_q[i] <= acc_wdata;
    end
  end

  always_comb begin
    acc_rdata = '0;
    for (int i = 0; i < DATA_WORDS; i++)
      if (dsel[i]) acc_rdata = data_q[i];
    for (int i = 0; i < PROG_WORDS; i++)
      if (psel[i]) acc_rdata = prog_q[i];
    if (busy_q && (data_hit || prog_hit))
      acc_rdata = '1;
  end

  assign busy    = busy_q;
  assign cmd_err = err_q;
  assign launch  = launch_q;
  assign cmd_out = cmd_q;

  a_r2_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    launch_q |-> busy_q);

  a_r3_no_launch_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != E_NONE) |=> !launch_q);

  a_r6_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(rti_tick));

  a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !rti_tick) |=> busy_q);

  a_r8_busy_access_err: assert property (@(posedge clk) disable iff (!rst_n)
    (data_hit && busy_q && err_q == E_NONE) |=> (err_q == E_BUSY));

  a_r10_sticky_err: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != E_NONE && !op_stat) |=> (err_q == $past(err_q)));

endmodule

// File: tb/abs_cmd_ctrl_test.sv
module abs_cmd_ctrl_test;
  localparam int WW = 32, ND = 2, NP = 4, CW = 8, IW = 2;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] idle_cfg = '0;
  logic hart_halted = 1, hart_done = 0, hart_exc = 0, rti_tick = 0;
  logic cmd_wr = 0, stat_wr = 0, auto_wr = 0, acc_req = 0, acc_prog = 0, acc_we = 0;
  logic [WW-1:0] cmd_wdata = '0, acc_wdata = '0;
  logic [2:0] stat_clr = '0;
  logic [ND-1:0] auto_data_mask = '0;
  logic [NP-1:0] auto_prog_mask = '0;
  logic [IW-1:0] acc_idx = '0;
  logic [WW-1:0] acc_rdata, cmd_out;
  logic busy, launch;
  logic [2:0] cmd_err;

  abs_cmd_ctrl #(.WORD_W(WW), .DATA_WORDS(ND), .PROG_WORDS(NP), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .idle_cfg(idle_cfg), .hart_halted(hart_halted),
    .hart_done(hart_done), .hart_exc(hart_exc), .rti_tick(rti_tick),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .stat_wr(stat_wr), .stat_clr(stat_clr),
    .auto_wr(auto_wr), .auto_data_mask(auto_data_mask), .auto_prog_mask(auto_prog_mask),
    .acc_req(acc_req), .acc_prog(acc_prog), .acc_we(acc_we), .acc_idx(acc_idx),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .busy(busy), .cmd_err(cmd_err),
    .launch(launch), .cmd_out(cmd_out));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_busy, m_err, m_cnt, m_done, m_launch;
  int unsigned m_cmd, m_dmask, m_pmask;
  int unsigned m_data [ND];
  int unsigned m_prog [NP];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_err = 0; m_cnt = 0; m_done = 0; m_launch = 0;
      m_cmd = 0; m_dmask = 0; m_pmask = 0;
      foreach (m_data[k]) m_data[k] = 0;
      foreach (m_prog[k]) m_prog[k] = 0;
    end else begin
      int ne, run, go, idx;
      int unsigned word;
      ne = m_err; run = 0; go = 0; word = m_cmd; idx = int'(acc_idx);
      if (cmd_wr) begin m_cmd = cmd_wdata; word = cmd_wdata; run = 1; end
      else if (stat_wr) ne = m_err & ~int'(stat_clr);
      else if (auto_wr) begin m_dmask = auto_data_mask; m_pmask = auto_prog_mask; end
      else if (acc_req) begin
        if (!acc_prog && idx < ND) begin
          if (m_busy != 0) begin if (m_err == 0) ne = 1; end
          else begin
            if (acc_we) m_data[idx] = acc_wdata;
            if (((m_dmask >> idx) & 1) != 0) run = 1;
          end
        end else if (acc_prog && idx < NP && m_busy == 0) begin
          if (acc_we) m_prog[idx] = acc_wdata;
          if (((m_pmask >> idx) & 1) != 0) run = 1;
        end
      end
      if (run != 0 && m_err == 0) begin
        if (m_busy != 0) ne = 1;
        else if ((word >> 24) != 0) ne = 2;
        else if (!hart_halted) ne = 4;
        else go = 1;
      end
      if (hart_exc && ne == 0) ne = 3;
      if (go != 0) begin m_busy = 1; m_done = 0; m_cnt = int'(idle_cfg); end
      else begin
        if (m_busy != 0 && hart_done) m_done = 1;
        if (rti_tick) begin
          if (m_cnt > 0) m_cnt--;
          if (m_busy != 0 && m_done != 0 && m_cnt == 0) m_busy = 0;
        end
      end
      m_err = ne; m_launch = go;
    end
  end

  function automatic longint model_rdata();
    int idx = int'(acc_idx);
    if (!acc_req || cmd_wr || stat_wr || auto_wr) return 0;
    if (!acc_prog && idx < ND) return (m_busy != 0) ? 64'hFFFF_FFFF : longint'(m_data[idx]);
    if (acc_prog && idx < NP) return (m_busy != 0) ? 64'hFFFF_FFFF : longint'(m_prog[idx]);
    return 0;
  endfunction

  always @(posedge clk) begin
    #5;
    if (rst_n && !finished) begin
      check("R6 model busy", busy, m_busy);
      check("R4 model err", cmd_err, m_err);
      check("R2 model launch", launch, m_launch);
      check("R2 model cmd_out", cmd_out, m_cmd);
      check("R7 model rdata", acc_rdata, model_rdata());
    end
  end

  task automatic idle_inputs();
    cmd_wr = 0; stat_wr = 0; auto_wr = 0; acc_req = 0; acc_we = 0;
    hart_done = 0; hart_exc = 0; rti_tick = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_cmd(input logic [WW-1:0] w);
    cmd_wr = 1; cmd_wdata = w; step();
  endtask
  task automatic do_clr(input logic [2:0] c);
    stat_wr = 1; stat_clr = c; step();
  endtask
  task automatic do_acc(input bit prog, input bit we, input int idx, input logic [WW-1:0] d);
    acc_req = 1; acc_prog = prog; acc_we = we; acc_idx = IW'(idx); acc_wdata = d; step();
  endtask
  task automatic read_chk(input string tag, input bit prog, input int idx, input longint exp);
    acc_req = 1; acc_prog = prog; acc_we = 0; acc_idx = IW'(idx);
    #1 check(tag, acc_rdata, exp);
    step();
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 busy", busy, 0); check("R1 err", cmd_err, 0);
    check("R1 launch", launch, 0); check("R1 cmd_out", cmd_out, 0);
    read_chk("R1 data word", 0, 1, 0);
    idle_cfg = 2;
    do_acc(0, 1, 0, 32'h11); do_acc(1, 1, 1, 32'h22);
    read_chk("R7 idle data read", 0, 0, 32'h11);
    read_chk("R7 out of range", 0, 3, 0);
    do_cmd(32'h0000_1234);
    check("R2 launch", launch, 1); check("R2 busy", busy, 1);
    check("R2 cmd_out", cmd_out, 32'h1234);
    step(); check("R2 one pulse", launch, 0);
    do_cmd(32'h0000_1234); check("R4 busy error", cmd_err, 1);
    do_clr(3'b001); check("R10 clear", cmd_err, 0);
    read_chk("R7 busy prog read", 1, 1, 32'hFFFF_FFFF);
    check("R8 prog no error", cmd_err, 0);
    do_acc(1, 1, 1, 32'h77);
    do_acc(0, 1, 0, 32'h99); check("R8 data access error", cmd_err, 1);
    do_clr(3'b111);
    rti_tick = 1; step(); rti_tick = 1; step(); rti_tick = 1; step();
    check("R6 no release without done", busy, 1);
    hart_done = 1; step(); check("R6 no release without tick", busy, 1);
    rti_tick = 1; step(); check("R6 release", busy, 0);
    read_chk("R8 data write discarded", 0, 0, 32'h11);
    read_chk("R8 prog write discarded", 1, 1, 32'h22);
    do_cmd(32'h0100_0000); check("R5 not supported", cmd_err, 2);
    do_cmd(32'h0000_0005); check("R3 no launch", busy, 0);
    check("R3 err kept", cmd_err, 2);
    do_clr(3'b010); hart_halted = 0;
    do_cmd(32'h0000_0005); check("R5 halt state", cmd_err, 4);
    hart_halted = 1; do_clr(3'b100);
    hart_exc = 1; step(); check("R11 exception", cmd_err, 3);
    do_clr(3'b010); check("R10 partial clear", cmd_err, 1);
    do_clr(3'b001);
    idle_cfg = 0;
    auto_wr = 1; auto_data_mask = 2'b01; auto_prog_mask = 4'b1000; step();
    do_acc(0, 1, 1, 32'h5); check("R9 unmasked word", busy, 0);
    do_acc(0, 1, 0, 32'h6); check("R9 data auto launch", launch, 1);
    hart_done = 1; rti_tick = 1; step(); check("R6 same-cycle done", busy, 0);
    do_acc(1, 0, 3, 0); check("R9 prog auto launch", launch, 1);
    hart_done = 1; rti_tick = 1; step();
    cmd_wr = 1; cmd_wdata = 32'h0200_0000; acc_req = 1; acc_prog = 0; acc_we = 1;
    acc_idx = 1; acc_wdata = 32'hAB; step();
    check("R12 command wins", cmd_err, 2);
    do_clr(3'b111);
    read_chk("R12 access dropped", 0, 1, 32'h5);

    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 99));
      idle_cfg = CW'($urandom_range(0, 3));
      hart_halted = ($urandom_range(0, 9) != 0);
      hart_done = ($urandom_range(0, 3) == 0);
      rti_tick = ($urandom_range(0, 1) == 0);
      hart_exc = ($urandom_range(0, 49) == 0);
      if (r < 10) begin
        cmd_wr = 1;
        cmd_wdata = ($urandom_range(0, 5) == 0) ? 32'h0300_0000 : $urandom_range(0, 255);
      end else if (r < 25) begin stat_wr = 1; stat_clr = 3'($urandom_range(0, 7)); end
      else if (r < 30) begin
        auto_wr = 1; auto_data_mask = ND'($urandom); auto_prog_mask = NP'($urandom);
      end else if (r < 70) begin
        acc_req = 1; acc_prog = $urandom_range(0, 1) == 1; acc_we = $urandom_range(0, 1) == 1;
        acc_idx = IW'($urandom); acc_wdata = $urandom;
      end
      if (r >= 95) begin cmd_wr = 1; stat_wr = 1; acc_req = 1; end
      step();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule